// File: doc/BRIEF.md
# Bidirectional Host-Slave Mailbox Arbiter

This block gives a host processor and a local slave processor a shared window of byte entries. Either side can use the window to pass a message to the other. Each side has its own port with an entry address, write data, a write strobe, a read strobe and combinational read data. Every entry is plain storage that both ports can read and write. Two entries also carry protocol meaning. Writing the first entry claims the window for the writing side, and a write-mode flag records which side holds it. Writing the last entry signals that a message is complete, and reading the last entry acknowledges it.

A status byte reports four flags. It is visible to both sides, and from the host side it is read-only. The slave has a separate status-write strobe, which it can use to drop only the output-full flag and its own write-mode flag. The input-full flag also drives an interrupt request toward the slave. All strobes are single-cycle levels that act on the rising clock edge. Neither port applies back-pressure, so every strobe is accepted in the cycle it is asserted.

Top module: `duplex_mailbox`

## Requirements
- R1: After reset the status byte reads 0x00, the interrupt is low, and every entry reads 0x00.
- R2: Each entry holds the last byte written to it by either port, and that byte can be read from both ports. When both ports write the same entry in one cycle, the host byte is kept.
- R3: Status bit 7 (input full) is set by a host write to entry 15 and cleared by a slave read of entry 15. The slave interrupt equals this bit.
- R4: Status bit 6 (output full) is set by a slave write to entry 15. It is cleared by a host read of entry 15, or by a slave status write with bit 6 equal to 0.
- R5: Status bit 5 (host owns) is set by a host write to entry 0 only while bit 4 is 0. It is cleared by a slave read of entry 15.
- R6: Status bit 4 (slave owns) is set by a slave write to entry 0 only while bit 5 is 0. It is cleared by a host read of entry 15, or by a slave status write with bit 4 equal to 0.
- R7: When host and slave both write entry 0 in the same cycle while neither owns the window, bit 5 is set and bit 4 stays 0. Bits 5 and 4 are never 1 together.
- R8: A slave status write never changes bits 7 or 5. Writing 1 to bit 6 or bit 4 leaves that bit unchanged. Status bits 3..0 always read 0.
- R9: When a set event and a clear event hit the same flag in one cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 4 | Host entry address |
| hst_wdata | input | 8 | Host write byte |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe (acknowledges entry 15) |
| hst_rdata | output | 8 | Host read byte for hst_addr |
| slv_addr | input | 4 | Slave entry address |
| slv_wdata | input | 8 | Slave write byte, also the status-write byte |
| slv_wr | input | 1 | Slave entry write strobe |
| slv_rd | input | 1 | Slave read strobe (acknowledges entry 15) |
| slv_stat_wr | input | 1 | Slave status write strobe (clear-by-zero) |
| slv_rdata | output | 8 | Slave read byte for slv_addr |
| mbx_status | output | 8 | Status byte {in_full, out_full, host_owns, slave_owns, 0000} |
| slv_irq | output | 1 | Interrupt request to the slave |

## Verification
The flags are driven with single-sided sequences: a host message and its slave acknowledge, and a slave message and its host acknowledge. These separate the set source from the clear source of each flag. Ownership is tried with a claim by one side followed by a claim attempt by the other, and with a same-cycle claim by both sides. This shows whether the interlock and the host priority hold. Status writes of all ones, all zeros and single-zero bytes show which flags a status write can touch. Same-cycle set-and-clear pairs and a same-entry double write show which event takes priority.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned BIT_IN_FULL  = 7;
  localparam int unsigned BIT_OUT_FULL = 6;
  localparam int unsigned BIT_HOST_OWN = 5;
  localparam int unsigned BIT_SLV_OWN  = 4;

  typedef struct packed {
    logic in_full;
    logic out_full;
    logic host_own;
    logic slv_own;
  } mbx_flags_t;

  typedef struct packed {
    logic hst_claim;
    logic slv_claim;
    logic hst_done;
    logic slv_done;
    logic hst_ack;
    logic slv_ack;
  } mbx_evt_t;
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  input  logic          h_we,
  output logic [DW-1:0] h_rdata,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_wdata,
  input  logic          s_we,
  output logic [DW-1:0] s_rdata
);
  logic [DW-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[i] <= '0;
      else if (h_we && h_addr == AW'(i))
        ent[i] <= h_wdata;
      else if (s_we && s_addr == AW'(i))
        ent[i] <= s_wdata;
    end
  end

  assign h_rdata = ent[h_addr];
  assign s_rdata = ent[s_addr];

  // R2
  host_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_we |=> ent[$past(h_addr)] == $past(h_wdata));
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mbx_evt_t      evt,
  input  logic          stat_we,
  input  logic [DW-1:0] stat_wdata,
  output mbx_flags_t    flg
);
  mbx_flags_t nxt;
  logic clr_out, clr_slv, set_slv, set_host;

  always_comb begin
    clr_out  = evt.hst_ack || (stat_we && !stat_wdata[BIT_OUT_FULL]);
    clr_slv  = evt.hst_ack || (stat_we && !stat_wdata[BIT_SLV_OWN]);
    set_host = evt.hst_claim && !flg.slv_own;
    set_slv  = evt.slv_claim && !flg.host_own && !evt.hst_claim;
    nxt = flg;
    if (evt.slv_ack) nxt.in_full  = 1'b0;
    if (evt.hst_done) nxt.in_full = 1'b1;
    if (clr_out)      nxt.out_full = 1'b0;
    if (evt.slv_done) nxt.out_full = 1'b1;
    if (evt.slv_ack)  nxt.host_own = 1'b0;
    if (set_host)     nxt.host_own = 1'b1;
    if (clr_slv)      nxt.slv_own  = 1'b0;
    if (set_slv)      nxt.slv_own  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flg <= '0;
    else        flg <= nxt;
  end

  // R7
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flg.host_own && flg.slv_own));
  // R7
  host_tie_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.hst_claim && evt.slv_claim && !flg.host_own && !flg.slv_own)
      |=> (flg.host_own && !flg.slv_own));
  // R3
  in_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.hst_done |=> flg.in_full);
  // R4
  out_full_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.hst_ack && !evt.slv_done) |=> !flg.out_full);
  // R8
  stat_keeps_host_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !evt.slv_ack && !evt.hst_done && !evt.hst_claim)
      |=> ($stable(flg.in_full) && $stable(flg.host_own)));
endmodule

// File: rtl/duplex_mailbox.sv
module duplex_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] hst_addr,
  input  logic [DW-1:0] hst_wdata,
  input  logic          hst_wr,
  input  logic          hst_rd,
  output logic [DW-1:0] hst_rdata,
  input  logic [AW-1:0] slv_addr,
  input  logic [DW-1:0] slv_wdata,
  input  logic          slv_wr,
  input  logic          slv_rd,
  input  logic          slv_stat_wr,
  output logic [DW-1:0] slv_rdata,
  output logic [DW-1:0] mbx_status,
  output logic          slv_irq
);
  localparam logic [AW-1:0] CLAIM_IDX = '0;
  localparam logic [AW-1:0] DONE_IDX  = AW'(DEPTH - 1);

  mbx_evt_t   evt;
  mbx_flags_t flg;

  always_comb begin
    evt.hst_claim = hst_wr && hst_addr == CLAIM_IDX;
    evt.slv_claim = slv_wr && slv_addr == CLAIM_IDX;
    evt.hst_done  = hst_wr && hst_addr == DONE_IDX;
    evt.slv_done  = slv_wr && slv_addr == DONE_IDX;
    evt.hst_ack   = hst_rd && hst_addr == DONE_IDX;
    evt.slv_ack   = slv_rd && slv_addr == DONE_IDX;
  end

  mbx_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_addr  (hst_addr),
    .h_wdata (hst_wdata),
    .h_we    (hst_wr),
    .h_rdata (hst_rdata),
    .s_addr  (slv_addr),
    .s_wdata (slv_wdata),
    .s_we    (slv_wr),
    .s_rdata (slv_rdata)
  );

  mbx_flags #(.DW(DW)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .stat_we    (slv_stat_wr),
    .stat_wdata (slv_wdata),
    .flg        (flg)
  );

  always_comb begin
    mbx_status = '0;
    mbx_status[BIT_IN_FULL]  = flg.in_full;
    mbx_status[BIT_OUT_FULL] = flg.out_full;
    mbx_status[BIT_HOST_OWN] = flg.host_own;
    mbx_status[BIT_SLV_OWN]  = flg.slv_own;
  end

  assign slv_irq = flg.in_full;

  // R8
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbx_status[3:0] == 4'h0);
endmodule

// File: tb/sim_duplex_mailbox.sv
`timescale 1ns/1ps
module sim_duplex_mailbox;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] hst_addr = '0, slv_addr = '0;
  logic [7:0] hst_wdata = '0, slv_wdata = '0;
  logic hst_wr = 0, hst_rd = 0, slv_wr = 0, slv_rd = 0, slv_stat_wr = 0;
  logic [7:0] hst_rdata, slv_rdata, mbx_status;
  logic slv_irq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  duplex_mailbox u0 (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, driven at negedge, released at the next negedge
  task automatic cyc(logic hw, logic [3:0] ha, logic [7:0] hd, logic hr,
                     logic sw, logic [3:0] sa, logic [7:0] sd, logic sr, logic st);
    hst_wr = hw; hst_addr = ha; hst_wdata = hd; hst_rd = hr;
    slv_wr = sw; slv_addr = sa; slv_wdata = sd; slv_rd = sr; slv_stat_wr = st;
    @(negedge clk);
    hst_wr = 0; hst_rd = 0; slv_wr = 0; slv_rd = 0; slv_stat_wr = 0;
  endtask

  task automatic t_reset;
    hst_addr = 4'd5; slv_addr = 4'd15; #1;
    check("R1 status", mbx_status, 8'h00);
    check("R1 irq", {7'b0, slv_irq}, 8'h00);
    check("R1 entry", hst_rdata, 8'h00);
    check("R1 entry15", slv_rdata, 8'h00);
  endtask

  task automatic t_store;
    cyc(1, 4'd3, 8'hA5, 0, 0, 0, 0, 0, 0);
    slv_addr = 4'd3; #1; check("R2 host->slave", slv_rdata, 8'hA5);
    cyc(0, 0, 0, 0, 1, 4'd7, 8'h3C, 0, 0);
    hst_addr = 4'd7; #1; check("R2 slave->host", hst_rdata, 8'h3C);
    cyc(1, 4'd9, 8'h11, 0, 1, 4'd9, 8'h22, 0, 0);
    hst_addr = 4'd9; slv_addr = 4'd9; #1;
    check("R2 same entry host kept", slv_rdata, 8'h11);
    check("R2 status untouched", mbx_status, 8'h00);
  endtask

  task automatic t_in_full;
    cyc(1, 4'd15, 8'h5A, 0, 0, 0, 0, 0, 0);
    check("R3 set", mbx_status, 8'h80);
    check("R3 irq", {7'b0, slv_irq}, 8'h01);
    cyc(0, 0, 0, 0, 0, 4'd15, 0, 1, 0);
    check("R3 cleared", mbx_status, 8'h00);
    check("R3 irq low", {7'b0, slv_irq}, 8'h00);
  endtask

  task automatic t_out_full;
    cyc(0, 0, 0, 0, 1, 4'd15, 8'h66, 0, 0);
    check("R4 set", mbx_status, 8'h40);
    cyc(0, 4'd15, 0, 1, 0, 0, 0, 0, 0);
    check("R4 host ack", mbx_status, 8'h00);
    cyc(0, 0, 0, 0, 1, 4'd15, 8'h67, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 8'hFF, 0, 1);
    check("R8 write one keeps", mbx_status, 8'h40);
    cyc(0, 0, 0, 0, 0, 0, 8'hBF, 0, 1);
    check("R4 slave clear", mbx_status, 8'h00);
  endtask

  task automatic t_host_own;
    cyc(1, 4'd0, 8'h01, 0, 0, 0, 0, 0, 0);
    check("R5 set", mbx_status, 8'h20);
    cyc(0, 0, 0, 0, 1, 4'd0, 8'h02, 0, 0);
    check("R6 blocked by host", mbx_status, 8'h20);
    cyc(0, 0, 0, 0, 0, 4'd15, 0, 1, 0);
    check("R5 cleared", mbx_status, 8'h00);
  endtask

  task automatic t_slv_own;
    cyc(0, 0, 0, 0, 1, 4'd0, 8'h03, 0, 0);
    check("R6 set", mbx_status, 8'h10);
    cyc(1, 4'd0, 8'h04, 0, 0, 0, 0, 0, 0);
    check("R5 blocked by slave", mbx_status, 8'h10);
    cyc(0, 4'd15, 0, 1, 0, 0, 0, 0, 0);
    check("R6 host ack", mbx_status, 8'h00);
    cyc(0, 0, 0, 0, 1, 4'd0, 8'h05, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 8'hEF, 0, 1);
    check("R6 slave clear", mbx_status, 8'h00);
  endtask

  task automatic t_tie;
    cyc(1, 4'd0, 8'hAA, 0, 1, 4'd0, 8'hBB, 0, 0);
    check("R7 host wins", mbx_status, 8'h20);
    hst_addr = 4'd0; #1; check("R7 entry0 host", hst_rdata, 8'hAA);
    cyc(0, 0, 0, 0, 0, 4'd15, 0, 1, 0);
    check("R7 cleanup", mbx_status, 8'h00);
  endtask

  task automatic t_stat_ignore;
    cyc(1, 4'd15, 8'h10, 0, 0, 0, 0, 0, 0);
    cyc(1, 4'd0, 8'h20, 0, 0, 0, 0, 0, 0);
    check("R8 precondition", mbx_status, 8'hA0);
    cyc(0, 0, 0, 0, 0, 0, 8'h00, 0, 1);
    check("R8 bits 7/5 kept", mbx_status, 8'hA0);
    cyc(0, 0, 0, 0, 0, 0, 8'h0F, 0, 1);
    check("R8 low bits zero", mbx_status, 8'hA0);
    cyc(0, 0, 0, 0, 0, 4'd15, 0, 1, 0);
    check("R8 cleanup", mbx_status, 8'h00);
  endtask

  task automatic t_set_wins;
    cyc(0, 4'd15, 0, 1, 1, 4'd15, 8'h77, 0, 0);
    check("R9 out_full set beats ack", mbx_status, 8'h40);
    cyc(1, 4'd15, 8'h78, 0, 0, 4'd15, 0, 1, 0);
    check("R9 in_full set beats ack", mbx_status, 8'hC0);
    cyc(0, 0, 0, 0, 1, 4'd15, 8'hBF, 0, 1);
    check("R9 out_full set beats status clear", mbx_status, 8'hC0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset; t_store; t_in_full; t_out_full; t_host_own;
        t_slv_own; t_tie; t_stat_ignore; t_set_wins;
      end
      begin
        repeat (5000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule